// File: doc/BRIEF.md
# Quarter-Square Modular Multiplier (q = 3329)

This block multiplies two residues modulo the prime 3329 without a hardware multiplier. It works from the identity a·b ≡ QS(a+b) − QS(a−b), where QS(x) = x²·4⁻¹ mod q. One dual-port table gives both quarter squares in the same cycle. The table is a quarter of the naive size for two reasons. The sum and the difference are each first mapped to min(x, q−x), since x² and (q−x)² agree mod q. The mapped value is then halved, so that only the entries for even arguments are stored. When the mapped argument is odd, a small correction term is added to the table value.

The operands must already be reduced below q. A new operand pair may be presented on every clock cycle, qualified by a valid strobe. The reduced product comes out exactly five cycles later with its own valid strobe. A butterfly datapath can place this unit in its twiddle multiply slot.

Top module: `qsq_modmul`

## Requirements
- R1: For every pair of operands below 3329, the result equals (a·b) mod 3329 and is itself below 3329.
- R2: `out_vld` is high exactly in the cycle five rising edges after `in_vld` was sampled high, and the product of that pair is on `out_p` in that cycle.
- R3: After synchronous reset is released, `out_vld` stays low until a valid pair has had its five cycles to pass through.
- R4: When either operand is zero, the result is zero.
- R5: When a + b equals 3329, so that the reduced sum wraps to zero, the result is still correct.
- R6: When a equals b, so that the reduced difference is zero, the result is a² mod 3329.
- R7: Operand pairs presented on consecutive cycles produce results on consecutive cycles, each one independent of its neighbours.
- R8: When a folded argument is odd (for example a=1, b=0 or a=2, b=1), the odd-index correction gives the right quarter square.
- R9: When the sum or the difference lies above 1664 (for example a=3000, b=100), the fold to q−x gives the right result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand pair valid |
| in_a | input | 12 | First operand, below 3329 |
| in_b | input | 12 | Second operand, below 3329 |
| out_vld | output | 1 | Product valid, five cycles after `in_vld` |
| out_p | output | 12 | Product (a·b) mod 3329 |

## Verification
The hardest cases to reach are those where the two table lookups of one pair take different paths. In these cases one argument is folded and the other is not, or one is odd and the other even. Uniform random operands reach them only by chance. The stimulus therefore adds directed pairs at the fold boundary (1664/1665), pairs whose sum wraps exactly to q, pairs with equal operands, and small odd/even mixes. These are placed back-to-back among thousands of random pairs, so that neighbouring results in the pipeline would show any leak from one pair into the next.

// File: rtl/qsq_pkg.sv
// Shared constants and constant functions for the quarter-square multiplier.
// Assumes an odd modulus, so the inverse of 4 exists.
package qsq_pkg;
    localparam int unsigned Q_DEFAULT = 3329;

    // Inverse of 4 modulo an odd q, in closed form.
    function automatic int unsigned inv4_of(input int unsigned q);
        if ((q % 4) == 1) return (3 * q + 1) / 4;
        else              return (q + 1) / 4;
    endfunction

    // Table entry for index m: QS(2m) = m*m mod q.
    function automatic int unsigned qs_even(input int unsigned m, input int unsigned q);
        return (m * m) % q;
    endfunction
endpackage

// File: rtl/qsq_prep.sv
// Pre-processing, two stages. Stage 1 forms the reduced sum and difference
// of the operands. Stage 2 folds each one into [0, q/2] and splits it into
// a table index and an odd flag. Assumes the operands are below q.
module qsq_prep #(
    parameter int unsigned Q = qsq_pkg::Q_DEFAULT,
    localparam int unsigned W     = $clog2(Q),
    localparam int unsigned HALF  = Q / 2,
    localparam int unsigned IDX_W = $clog2(HALF / 2 + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [W-1:0]          in_a,
    input  logic [W-1:0]          in_b,
    output logic                  out_vld,
    output logic [1:0][IDX_W-1:0] out_idx,
    output logic [1:0]            out_odd
);
    logic [W:0]        sum_raw;
    logic [1:0][W-1:0] arg_c, arg_q;
    logic              vld_q;

    // Reduced sum and difference of the operands.
    always_comb begin
        sum_raw  = {1'b0, in_a} + {1'b0, in_b};
        arg_c[0] = (sum_raw >= (W+1)'(Q)) ? W'(sum_raw - (W+1)'(Q)) : W'(sum_raw);
        arg_c[1] = (in_a >= in_b) ? (in_a - in_b) : W'((W+1)'(in_a) + (W+1)'(Q) - (W+1)'(in_b));
    end

    // Stage 1 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            arg_q <= '0;
        end else begin
            vld_q <= in_vld;
            arg_q <= arg_c;
        end
    end

    // Stage 2: fold by symmetry, then halve into index and odd flag.
    for (genvar g = 0; g < 2; g++) begin : g_fold
        logic [W-1:0] folded;
        always_comb folded = (arg_q[g] > W'(HALF)) ? (W'(Q) - arg_q[g]) : arg_q[g];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_idx[g] <= '0;
                out_odd[g] <= 1'b0;
            end else begin
                out_idx[g] <= IDX_W'(folded >> 1);
                out_odd[g] <= folded[0];
            end
        end
    end

    // Valid follows the data through stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= vld_q;
    end
endmodule

// File: rtl/qsq_rom.sv
// Dual-port quarter-square table with a registered read. Entry m holds QS(2m).
// Both ports read in the same cycle. Contents come from a constant function.
module qsq_rom #(
    parameter int unsigned Q = qsq_pkg::Q_DEFAULT,
    localparam int unsigned W     = $clog2(Q),
    localparam int unsigned IDX_W = $clog2(Q / 4 + 1),
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][IDX_W-1:0] rd_idx,
    output logic [1:0][W-1:0]     rd_data
);
    logic [W-1:0] table_q [DEPTH];

    // Fill the table with even-argument quarter squares.
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign table_q[i] = W'(qsq_pkg::qs_even(i, Q));
    end

    // One registered read per port.
    for (genvar p = 0; p < 2; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n) rd_data[p] <= '0;
            else        rd_data[p] <= table_q[rd_idx[p]];
        end
    end
endmodule

// File: rtl/qsq_post.sv
// Post-processing, two stages. Stage 4 adds m + 4^-1 to an odd argument's
// table value and reduces it. Stage 5 subtracts the two quarter squares
// mod q. Assumes the table values are below q.
module qsq_post #(
    parameter int unsigned Q = qsq_pkg::Q_DEFAULT,
    localparam int unsigned W     = $clog2(Q),
    localparam int unsigned IDX_W = $clog2(Q / 4 + 1),
    localparam int unsigned INV4  = qsq_pkg::inv4_of(Q)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [1:0][W-1:0]     in_even,
    input  logic [1:0][IDX_W-1:0] in_idx,
    input  logic [1:0]            in_odd,
    output logic                  out_vld,
    output logic [W-1:0]          out_p
);
    logic [1:0][W-1:0] qs_q;
    logic              vld_q;

    // Stage 4: odd-argument correction for each lookup.
    for (genvar g = 0; g < 2; g++) begin : g_fix
        logic [W:0] acc;
        always_comb acc = {1'b0, in_even[g]}
                        + (in_odd[g] ? ((W+1)'(in_idx[g]) + (W+1)'(INV4)) : '0);
        always_ff @(posedge clk) begin
            if (!rst_n) qs_q[g] <= '0;
            else        qs_q[g] <= (acc >= (W+1)'(Q)) ? W'(acc - (W+1)'(Q)) : W'(acc);
        end
    end

    // Stage 4 valid.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= in_vld;
    end

    // Stage 5: QS(sum) - QS(diff), with q added back when it goes negative.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_p   <= '0;
        end else begin
            out_vld <= vld_q;
            out_p   <= (qs_q[0] >= qs_q[1]) ? (qs_q[0] - qs_q[1])
                                            : W'((W+1)'(qs_q[0]) + (W+1)'(Q) - (W+1)'(qs_q[1]));
        end
    end
endmodule

// File: rtl/qsq_modmul.sv
// Top level: (a*b) mod q from quarter squares, five-cycle fixed latency.
// Operands must be below q. One pair may be accepted every cycle.
module qsq_modmul #(
    parameter int unsigned Q = qsq_pkg::Q_DEFAULT,
    localparam int unsigned W     = $clog2(Q),
    localparam int unsigned IDX_W = $clog2(Q / 4 + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_vld,
    output logic [W-1:0] out_p
);
    logic                  pre_vld;
    logic [1:0][IDX_W-1:0] pre_idx;
    logic [1:0]            pre_odd;
    logic [1:0][W-1:0]     rom_data;
    logic                  al_vld;
    logic [1:0][IDX_W-1:0] al_idx;
    logic [1:0]            al_odd;

    qsq_prep #(.Q(Q)) u_prep (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .out_vld(pre_vld), .out_idx(pre_idx), .out_odd(pre_odd)
    );

    qsq_rom #(.Q(Q)) u_rom (
        .clk(clk), .rst_n(rst_n), .rd_idx(pre_idx), .rd_data(rom_data)
    );

    // Stage 3: hold the index, odd flag and valid level with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_vld <= 1'b0;
            al_idx <= '0;
            al_odd <= '0;
        end else begin
            al_vld <= pre_vld;
            al_idx <= pre_idx;
            al_odd <= pre_odd;
        end
    end

    qsq_post #(.Q(Q)) u_post (
        .clk(clk), .rst_n(rst_n), .in_vld(al_vld), .in_even(rom_data),
        .in_idx(al_idx), .in_odd(al_odd), .out_vld(out_vld), .out_p(out_p)
    );
endmodule

// File: rtl/qsq_modmul_chk.sv
// Port-level checker for qsq_modmul, attached by bind.
module qsq_modmul_chk #(
    parameter int unsigned Q = qsq_pkg::Q_DEFAULT,
    localparam int unsigned W = $clog2(Q)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_vld,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_vld,
    input logic [W-1:0] out_p
);
    logic [2:0] since_rst;

    // Count cycles since reset release, saturating at the latency.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_rst <= '0;
        else if (since_rst < 5) since_rst <= since_rst + 3'd1;
    end

    // R1
    range_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_p < W'(Q)));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5) |-> (out_vld == $past(in_vld, 5)));

    // R3
    idle_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'd5) |-> !out_vld);

    // R4
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 3'd5) && out_vld && (($past(in_a, 5) == '0) || ($past(in_b, 5) == '0)))
        |-> (out_p == '0));
endmodule

bind qsq_modmul qsq_modmul_chk #(.Q(Q)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .out_vld(out_vld), .out_p(out_p)
);

// File: tb/sim_qsq_modmul.sv
// Bench for qsq_modmul: directed corner pairs plus seeded random pairs,
// checked against a*b mod q computed here.
module sim_qsq_modmul;
    localparam int Q = 3329;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [11:0] in_a = '0;
    logic [11:0] in_b = '0;
    logic        out_vld;
    logic [11:0] out_p;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    bit    ring_v [8];
    int    ring_e [8];
    string ring_t [8];

    always #2.5 clk = ~clk;

    qsq_modmul u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_p(out_p)
    );

    function automatic int ref_mul(input int a, input int b);
        return (a * b) % Q;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Count rising edges once monitoring has started.
    always @(posedge clk) if (mon_on) cyc <= cyc + 1;

    // Compare the outputs with the pair driven five edges earlier.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            int s;
            s = (cyc + 3) & 7;
            check(ring_v[s] ? {"R2 vld ", ring_t[s]} : "R2 idle", int'(out_vld), int'(ring_v[s]));
            if (ring_v[s] && out_vld) check(ring_t[s], int'(out_p), ring_e[s]);
        end
    end

    task automatic drive(input bit v, input int a, input int b, input string tag);
        @(negedge clk);
        in_vld = v;
        in_a   = 12'(a);
        in_b   = 12'(b);
        ring_v[cyc & 7] = v;
        ring_e[cyc & 7] = ref_mul(a, b);
        ring_t[cyc & 7] = tag;
    endtask

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        for (int i = 0; i < 8; i++) begin
            ring_v[i] = 1'b0; ring_e[i] = 0; ring_t[i] = "";
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R3: idle output after reset release
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R3", int'(out_vld), 0);
        end
        mon_on = 1'b1;
        // R4: zero operands
        drive(1, 0, 0, "R4");
        drive(1, 0, 3328, "R4");
        drive(1, 1234, 0, "R4");
        // R5: sum wraps exactly to q
        drive(1, 1664, 1665, "R5");
        drive(1, 1, 3328, "R5");
        drive(1, 3000, 329, "R5");
        // R6: equal operands
        drive(1, 3328, 3328, "R6");
        drive(1, 1665, 1665, "R6");
        drive(1, 7, 7, "R6");
        // R8: odd folded arguments
        drive(1, 1, 0, "R8");
        drive(1, 2, 1, "R8");
        drive(1, 5, 2, "R8");
        // R9: arguments above q/2 are folded
        drive(1, 3000, 100, "R9");
        drive(1, 1665, 0, "R9");
        drive(1, 100, 3000, "R9");
        drive(1, 2500, 2400, "R9");
        drive(0, 0, 0, "idle");
        // R7: random pairs every cycle
        for (int i = 0; i < 1500; i++)
            drive(1, int'($urandom % Q), int'($urandom % Q), "R7");
        // R1: random pairs with random gaps and equal-operand mixes
        for (int i = 0; i < 2000; i++) begin
            int a, b;
            a = int'($urandom % Q);
            b = ((i % 17) == 0) ? a : int'($urandom % Q);
            drive(($urandom % 4) != 0, a, b, "R1");
        end
        repeat (8) drive(0, 0, 0, "idle");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule